// File: doc/BRIEF.md
# Floating-Point Register Stack Controller

This block holds the eight-entry register stack of a floating-point unit: a rotating top-of-stack pointer, a two-bit tag for each physical slot and the slot contents, held here as 64-bit words. Every register reference made by a command is relative to the pointer. Logical register `i` lives in physical slot `(top + i) mod 8`. Data and tags travel together on every move.

The surrounding execution logic issues at most one command per cycle on a set of single-bit strobes. The available commands are initialise, push, pop, pointer increment, pointer decrement, free, copy-top (plain or popping), load onto stack and exchange. Every command takes effect at the next rising clock edge. The block shows the pointer, all eight tags and the value in the current top slot. No arithmetic, memory traffic, exception or overflow detection takes place here.

Top module: `fp_reg_stack`

## Requirements
- R1: While `rst_n` is low at a rising edge, the pointer becomes 0, every tag becomes empty (2'b11) and every slot's data becomes zero.
- R2: `init_i` sets the pointer to 0 and marks all eight tags empty (2'b11). It leaves slot data unchanged.
- R3: Logical index `slot_i` always addresses physical slot `(top_o + slot_i) mod 8`.
- R4: A push moves the pointer down by one modulo 8, so 0 wraps to 7. It then writes `push_data_i` into the new top slot and sets that slot's tag to valid (2'b00).
- R5: A pop marks the current top slot empty and then moves the pointer up by one modulo 8. Slot data stays as it was.
- R6: Pointer increment and pointer decrement change the pointer by one modulo 8 and change no tag and no data.
- R7: A free writes the empty tag into the slot of logical `slot_i`. It leaves the pointer and all data unchanged.
- R8: A copy-top writes the top slot's data and tag into logical `slot_i`. The pointer does not move.
- R9: A popping copy-top does the copy of R8, then marks the old top slot empty and moves the pointer up by one. With `slot_i` = 0 the slot ends up empty.
- R10: A load reads the data and tag of logical `slot_i` before the push. It then moves the pointer down by one and writes both values into the new top slot.
- R11: An exchange swaps both data and tag between logical 0 and logical `slot_i` in one cycle. The pointer does not move.
- R12: When several strobes are high in the same cycle, only the highest-priority one acts. The order from highest to lowest is init, push, pop, increment, decrement, free, copy-top, popping copy-top, load, exchange.
- R13: `tags_o[2k+1:2k]` carries the tag of physical slot k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| init_i | input | 1 | Initialise the stack |
| push_i | input | 1 | Push `push_data_i` |
| pop_i | input | 1 | Pop the top slot |
| inc_i | input | 1 | Increment the pointer |
| dec_i | input | 1 | Decrement the pointer |
| free_i | input | 1 | Mark logical `slot_i` empty |
| store_i | input | 1 | Copy top to logical `slot_i` |
| storep_i | input | 1 | Copy top to logical `slot_i`, then pop |
| load_i | input | 1 | Push a copy of logical `slot_i` |
| xchg_i | input | 1 | Exchange top with logical `slot_i` |
| slot_i | input | 3 | Logical register index |
| push_data_i | input | 64 | Data for push |
| top_o | output | 3 | Top-of-stack pointer |
| tags_o | output | 16 | Tags of all physical slots, two bits each |
| top_data_o | output | 64 | Data in the top slot |

## Verification
The bound checker looks at every cycle in which a single strobe is high. It checks how the pointer moves for each command, that a pushed word reaches the top with a valid tag, that pop and free leave an empty tag in the right slot, that increment and decrement leave the tags alone, and that init takes effect even when other strobes are also high. Some behaviour only shows up through the bench scenarios, because it depends on data that is not at the top: copy, load and exchange moving data along with tags to arbitrary offsets, init leaving data intact, and the full priority order across all 1023 strobe combinations. The bench brings that data into view by rotating the pointer through every slot.

// File: rtl/fstk_pkg.sv
// Shared definitions for the register stack: command strobe positions,
// the decoded operation type and the tag encodings.
package fstk_pkg;
    localparam int NUM_CMD = 10;
    // Strobe positions in the request vector; lower index wins.
    localparam int C_INIT   = 0;
    localparam int C_PUSH   = 1;
    localparam int C_POP    = 2;
    localparam int C_INC    = 3;
    localparam int C_DEC    = 4;
    localparam int C_FREE   = 5;
    localparam int C_STORE  = 6;
    localparam int C_STOREP = 7;
    localparam int C_LOAD   = 8;
    localparam int C_XCHG   = 9;

    typedef enum logic [3:0] {
        OP_IDLE, OP_INIT, OP_PUSH, OP_POP, OP_INC, OP_DEC,
        OP_FREE, OP_STORE, OP_STOREP, OP_LOAD, OP_XCHG
    } op_e;

    localparam logic [1:0] TAG_VALID = 2'b00;
    localparam logic [1:0] TAG_EMPTY = 2'b11;
endpackage

// File: rtl/fstk_cmd_sel.sv
// Command selector: turns the strobe vector into a single operation.
// Assumes strobe bit b maps to operation b+1 of op_e. A lower bit index has
// higher priority.
module fstk_cmd_sel
    import fstk_pkg::*;
(
    input  logic [NUM_CMD-1:0] req,
    output op_e                op
);
    // Priority pick: scan from lowest priority up so the strongest strobe wins.
    always_comb begin
        op = OP_IDLE;
        for (int b = NUM_CMD - 1; b >= 0; b--) begin
            if (req[b]) op = op_e'(4'(b + 1));
        end
    end
endmodule

// File: rtl/fstk_top_ptr.sv
// Top-of-stack pointer register. Moves modulo the stack depth, which must be
// a power of two so that plain wrap-around arithmetic gives the modulo.
module fstk_top_ptr
    import fstk_pkg::*;
#(
    parameter  int DEPTH = 8,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  op_e              op,
    output logic [PTR_W-1:0] top
);
    logic [PTR_W-1:0] top_nx;

    // Next pointer: pushes and loads go down, pops go up.
    always_comb begin
        case (op)
            OP_INIT:                   top_nx = '0;
            OP_PUSH, OP_LOAD, OP_DEC:  top_nx = top - 1'b1;
            OP_POP, OP_STOREP, OP_INC: top_nx = top + 1'b1;
            default:                   top_nx = top;
        endcase
    end

    // Pointer register with synchronous reset to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) top <= '0;
        else        top <= top_nx;
    end
endmodule

// File: rtl/fstk_slots.sv
// Slot storage: data and tag for each physical slot. Each slot works out its
// own next value from the current operation, the pointer and the logical index.
// Assumes DEPTH is a power of two. Every source value is read from registered
// state, so a load or exchange always sees the values from before the edge.
module fstk_slots
    import fstk_pkg::*;
#(
    parameter  int DEPTH  = 8,
    parameter  int DATA_W = 64,
    localparam int PTR_W  = $clog2(DEPTH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  op_e                 op,
    input  logic [PTR_W-1:0]    top,
    input  logic [PTR_W-1:0]    idx,
    input  logic [DATA_W-1:0]   push_data,
    output logic [2*DEPTH-1:0]  tag_flat,
    output logic [DATA_W-1:0]   top_data
);
    logic [DATA_W-1:0] rd_data [DEPTH];
    logic [1:0]        rd_tag  [DEPTH];
    logic [PTR_W-1:0]  dst;
    logic [PTR_W-1:0]  below;
    logic [DATA_W-1:0] cur_d, dst_d;
    logic [1:0]        cur_t, dst_t;

    assign dst      = top + idx;
    assign below    = top - 1'b1;
    assign cur_d    = rd_data[top];
    assign cur_t    = rd_tag[top];
    assign dst_d    = rd_data[dst];
    assign dst_t    = rd_tag[dst];
    assign top_data = cur_d;

    for (genvar k = 0; k < DEPTH; k++) begin : g_slot
        localparam logic [PTR_W-1:0] SLOT = PTR_W'(k);
        logic [DATA_W-1:0] d_q, d_nx;
        logic [1:0]        t_q, t_nx;

        // Next-state for one slot under the current operation.
        always_comb begin
            d_nx = d_q;
            t_nx = t_q;
            case (op)
                OP_INIT: t_nx = TAG_EMPTY;
                OP_PUSH: if (SLOT == below) begin
                    d_nx = push_data;
                    t_nx = TAG_VALID;
                end
                OP_POP:  if (SLOT == top) t_nx = TAG_EMPTY;
                OP_FREE: if (SLOT == dst) t_nx = TAG_EMPTY;
                OP_STORE, OP_STOREP: begin
                    if (SLOT == dst) begin
                        d_nx = cur_d;
                        t_nx = cur_t;
                    end
                    if (op == OP_STOREP && SLOT == top) t_nx = TAG_EMPTY;
                end
                OP_LOAD: if (SLOT == below) begin
                    d_nx = dst_d;
                    t_nx = dst_t;
                end
                OP_XCHG: begin
                    if (SLOT == top) begin
                        d_nx = dst_d;
                        t_nx = dst_t;
                    end else if (SLOT == dst) begin
                        d_nx = cur_d;
                        t_nx = cur_t;
                    end
                end
                default: ;
            endcase
        end

        // Slot registers, cleared by reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                d_q <= '0;
                t_q <= TAG_EMPTY;
            end else begin
                d_q <= d_nx;
                t_q <= t_nx;
            end
        end

        assign rd_data[k]         = d_q;
        assign rd_tag[k]          = t_q;
        assign tag_flat[2*k +: 2] = t_q;
    end
endmodule

// File: rtl/fp_reg_stack.sv
// Floating-point register stack controller. It takes single-cycle command
// strobes and keeps a rotating top pointer, per-slot tags and slot data.
// Assumes the caller normally raises one strobe per cycle. Extra strobes are
// resolved by fixed priority. Reset is synchronous and active low.
module fp_reg_stack
    import fstk_pkg::*;
#(
    parameter  int DEPTH  = 8,
    parameter  int DATA_W = 64,
    localparam int PTR_W  = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               init_i,
    input  logic               push_i,
    input  logic               pop_i,
    input  logic               inc_i,
    input  logic               dec_i,
    input  logic               free_i,
    input  logic               store_i,
    input  logic               storep_i,
    input  logic               load_i,
    input  logic               xchg_i,
    input  logic [PTR_W-1:0]   slot_i,
    input  logic [DATA_W-1:0]  push_data_i,
    output logic [PTR_W-1:0]   top_o,
    output logic [2*DEPTH-1:0] tags_o,
    output logic [DATA_W-1:0]  top_data_o
);
    logic [NUM_CMD-1:0] req;
    op_e                op;

    // Gather the strobes into priority order.
    always_comb begin
        req           = '0;
        req[C_INIT]   = init_i;
        req[C_PUSH]   = push_i;
        req[C_POP]    = pop_i;
        req[C_INC]    = inc_i;
        req[C_DEC]    = dec_i;
        req[C_FREE]   = free_i;
        req[C_STORE]  = store_i;
        req[C_STOREP] = storep_i;
        req[C_LOAD]   = load_i;
        req[C_XCHG]   = xchg_i;
    end

    fstk_cmd_sel u_sel (
        .req (req),
        .op  (op)
    );

    fstk_top_ptr #(.DEPTH(DEPTH)) u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .op    (op),
        .top   (top_o)
    );

    fstk_slots #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_slots (
        .clk       (clk),
        .rst_n     (rst_n),
        .op        (op),
        .top       (top_o),
        .idx       (slot_i),
        .push_data (push_data_i),
        .tag_flat  (tags_o),
        .top_data  (top_data_o)
    );
endmodule

// File: rtl/fp_reg_stack_chk.sv
// Protocol checker for fp_reg_stack. It watches only the ports. The
// command-specific properties fire only in cycles with exactly one strobe high.
module fp_reg_stack_chk #(
    parameter  int DEPTH  = 8,
    parameter  int DATA_W = 64,
    localparam int PTR_W  = $clog2(DEPTH)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               init_i,
    input logic               push_i,
    input logic               pop_i,
    input logic               inc_i,
    input logic               dec_i,
    input logic               free_i,
    input logic               store_i,
    input logic               storep_i,
    input logic               load_i,
    input logic               xchg_i,
    input logic [PTR_W-1:0]   slot_i,
    input logic [DATA_W-1:0]  push_data_i,
    input logic [PTR_W-1:0]   top_o,
    input logic [2*DEPTH-1:0] tags_o,
    input logic [DATA_W-1:0]  top_data_o
);
    logic [9:0]       reqv;
    logic             solo;
    logic [PTR_W-1:0] top_d, slot_d, free_slot;

    assign reqv = {xchg_i, load_i, storep_i, store_i, free_i,
                   dec_i, inc_i, pop_i, push_i, init_i};
    assign solo = ($countones(reqv) == 1);

    // Previous-cycle copies of pointer and index for slot-addressed checks.
    always_ff @(posedge clk) begin
        top_d  <= top_o;
        slot_d <= slot_i;
    end
    assign free_slot = top_d + slot_d;

    AST_RESET_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (top_o == '0 && tags_o == '1 && top_data_o == '0)); // R1
    AST_INIT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        init_i |=> (top_o == '0 && tags_o == '1)); // R2
    AST_INIT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (init_i && (push_i || pop_i || dec_i)) |=> top_o == '0); // R12
    AST_PUSH_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        (solo && push_i) |=> top_o == PTR_W'($past(top_o) - 1'b1)); // R4
    AST_PUSH_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (solo && push_i) |=> (top_data_o == $past(push_data_i)
                              && tags_o[2*top_o +: 2] == 2'b00)); // R4
    AST_POP_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        (solo && pop_i) |=> top_o == PTR_W'($past(top_o) + 1'b1)); // R5
    AST_POP_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        (solo && pop_i) |=> tags_o[2*top_d +: 2] == 2'b11); // R5
    AST_INCDEC_TAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (solo && (inc_i || dec_i)) |=> $stable(tags_o)); // R6
    AST_FREE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (solo && free_i) |=> ($stable(top_o) && tags_o[2*free_slot +: 2] == 2'b11)); // R7
    AST_STORE_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        (solo && store_i) |=> $stable(top_o)); // R8
    AST_STOREP_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        (solo && storep_i) |=> top_o == PTR_W'($past(top_o) + 1'b1)); // R9
    AST_LOAD_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        (solo && load_i) |=> top_o == PTR_W'($past(top_o) - 1'b1)); // R10
    AST_XCHG_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        (solo && xchg_i) |=> $stable(top_o)); // R11
endmodule

bind fp_reg_stack fp_reg_stack_chk #(.DEPTH(DEPTH), .DATA_W(DATA_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .init_i      (init_i),
    .push_i      (push_i),
    .pop_i       (pop_i),
    .inc_i       (inc_i),
    .dec_i       (dec_i),
    .free_i      (free_i),
    .store_i     (store_i),
    .storep_i    (storep_i),
    .load_i      (load_i),
    .xchg_i      (xchg_i),
    .slot_i      (slot_i),
    .push_data_i (push_data_i),
    .top_o       (top_o),
    .tags_o      (tags_o),
    .top_data_o  (top_data_o)
);

// File: tb/fp_reg_stack_tb_top.sv
// Self-checking bench. A reference model built from the requirements runs
// alongside the design. The bench sweeps every command at every index and
// every strobe combination, and rotates the pointer to bring each slot to the top.
module fp_reg_stack_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [9:0]  cmd;
    logic [2:0]  slot;
    logic [63:0] pdata;
    logic [2:0]  top_o;
    logic [15:0] tags_o;
    logic [63:0] top_data_o;

    int checks = 0;
    int errors = 0;

    // Reference model state.
    logic [63:0] m_data [8];
    logic [1:0]  m_tag  [8];
    logic [2:0]  m_top;
    logic [63:0] lfsr = 64'h1234_5678_9ABC_DEF1;

    always #(CLK_PERIOD/2) clk = ~clk;

    fp_reg_stack dut_i (
        .clk(clk), .rst_n(rst_n),
        .init_i(cmd[0]), .push_i(cmd[1]), .pop_i(cmd[2]), .inc_i(cmd[3]),
        .dec_i(cmd[4]), .free_i(cmd[5]), .store_i(cmd[6]), .storep_i(cmd[7]),
        .load_i(cmd[8]), .xchg_i(cmd[9]),
        .slot_i(slot), .push_data_i(pdata),
        .top_o(top_o), .tags_o(tags_o), .top_data_o(top_data_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic compare(input string req);
        logic [15:0] etags;
        for (int k = 0; k < 8; k++) etags[2*k +: 2] = m_tag[k];
        check(top_o == m_top, req, "pointer", 64'(top_o), 64'(m_top));
        check(tags_o == etags, {"R13 ", req}, "tags", 64'(tags_o), 64'(etags));
        check(top_data_o == m_data[m_top], req, "top data", top_data_o, m_data[m_top]);
    endtask

    function automatic string req_of(input int op);
        case (op)
            0: return "R2";  1: return "R4";  2: return "R5";
            3: return "R6";  4: return "R6";  5: return "R7";
            6: return "R8";  7: return "R9";  8: return "R10";
            default: return "R11";
        endcase
    endfunction

    // Apply the highest-priority strobe to the model (R12 order: bit 0 first).
    task automatic model(input logic [9:0] c, input logic [2:0] i, input logic [63:0] d);
        int op;
        logic [2:0] dst;
        logic [63:0] sd;
        logic [1:0] st;
        op = -1;
        for (int b = 9; b >= 0; b--) if (c[b]) op = b;
        dst = m_top + i;
        case (op)
            0: begin m_top = 0; for (int k = 0; k < 8; k++) m_tag[k] = 2'b11; end
            1: begin m_top = m_top - 1; m_data[m_top] = d; m_tag[m_top] = 2'b00; end
            2: begin m_tag[m_top] = 2'b11; m_top = m_top + 1; end
            3: m_top = m_top + 1;
            4: m_top = m_top - 1;
            5: m_tag[dst] = 2'b11;
            6: begin m_data[dst] = m_data[m_top]; m_tag[dst] = m_tag[m_top]; end
            7: begin
                m_data[dst] = m_data[m_top]; m_tag[dst] = m_tag[m_top];
                m_tag[m_top] = 2'b11; m_top = m_top + 1;
            end
            8: begin
                sd = m_data[dst]; st = m_tag[dst];
                m_top = m_top - 1; m_data[m_top] = sd; m_tag[m_top] = st;
            end
            9: begin
                sd = m_data[dst]; st = m_tag[dst];
                m_data[dst] = m_data[m_top]; m_tag[dst] = m_tag[m_top];
                m_data[m_top] = sd; m_tag[m_top] = st;
            end
            default: ;
        endcase
    endtask

    // Called at a falling edge: drive, update the model, check at the next falling edge.
    task automatic step(input logic [9:0] c, input logic [2:0] i, input string req);
        lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
        cmd = c; slot = i; pdata = lfsr;
        model(c, i, lfsr);
        @(negedge clk);
        compare(req);
    endtask

    // Step through all slots with increments so every data word reaches the top.
    task automatic rotate_view();
        for (int r = 0; r < 8; r++) step(10'b0000001000, 3'd0, "R3 R6");
    endtask

    task automatic do_reset();
        rst_n = 1'b0; cmd = '0; slot = '0; pdata = '0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        m_top = 0;
        for (int k = 0; k < 8; k++) begin m_data[k] = '0; m_tag[k] = 2'b11; end
        compare("R1");
    endtask

    initial begin
        cmd = '0; slot = '0; pdata = '0; rst_n = 1'b0;
        do_reset();
        // Fill the stack; the first push wraps the pointer from 0 to 7.
        for (int n = 0; n < 8; n++) step(10'b0000000010, 3'd0, "R4");
        rotate_view();
        // Every command at every logical index, refilled and viewed after each.
        for (int op = 1; op < 10; op++) begin
            for (int i = 0; i < 8; i++) begin
                step(10'(1 << op), 3'(i), req_of(op));
                rotate_view();
                step(10'b0000000010, 3'(i), "R4");
                step(10'b0000100000, 3'((i + 3) % 8), "R7");
                step(10'b0100000000, 3'((i + 3) % 8), "R10 R3");
            end
        end
        // Init keeps data: view all slots after it.
        step(10'b0000000001, 3'd5, "R2");
        rotate_view();
        for (int n = 0; n < 5; n++) step(10'b0000000010, 3'd0, "R4");
        // Every strobe combination resolves by priority.
        for (int v = 1; v < 1024; v++) begin
            step(10'(v), 3'(v % 8), "R12");
            if (v % 64 == 0) rotate_view();
        end
        rotate_view();
        // Reset in the middle of activity.
        do_reset();
        step(10'b0000000010, 3'd0, "R4");
        step(10'b1000000000, 3'd7, "R11");
        cmd = '0;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog R1 actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule